// File: doc/BRIEF.md
# Four-Way Set-Associative Line Cache

This block is the lookup and storage core of a data cache. It keeps 128 sets of four ways. Each way holds a 16-byte line made of four 32-bit longwords, together with a 21-bit address tag, a valid flag and a modified flag. Every access presents a longword-aligned address. The block indexes one set, compares the four stored tags in parallel and answers one cycle later with a hit or a miss. On a read hit it returns the selected longword. On a write hit it merges the enabled bytes into the line. Copyback writes mark the line modified. Write-through writes leave the modified flag alone and are also forwarded to memory on a one-cycle strobe.

On a miss the block reports which way the surrounding controller should refill. It prefers the lowest-numbered invalid way of the set. When the set is full, it uses a single rotating two-bit pointer instead. The controller later loads the whole line through the fill port in a single cycle. The cache does not handle bus protocol, victim write-back or flush.

Top module: `cache4_top`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid and unmodified, and the rotating pointer is 0. While reset is held and in the first cycle after it, all response outputs are zero.
- R2: Address bits [10:4] select the set and bits [31:11] are the tag. Bits [3:2] select the longword. Bits [1:0] have no effect on any result, and the forwarded memory address has them cleared.
- R3: An access accepted at one clock edge produces its response at the next edge. `rsp_hit` is 1 only if a way of the indexed set is valid and holds the access tag. If more than one way matches, the lowest-numbered one is used.
- R4: A read hit returns longword [3:2] of the hit line on `rsp_rdata`, and `rsp_way` gives the hit way. In every other cycle `rsp_rdata` is zero.
- R5: A write hit updates the addressed longword in place. Byte-enable bit i selects data bits [8i+7:8i]. The other bytes and longwords keep their values.
- R6: On every hit, `rsp_dirty` shows the line's modified flag as it stood before the access. A copyback write hit sets the flag. A write-through write hit leaves the flag unchanged and pulses `mem_wr` for one cycle with the address, data and byte enables. No other access pulses `mem_wr`.
- R7: A miss raises `rsp_miss`. If the set has an invalid way, `rsp_way` is the lowest-numbered invalid way.
- R8: On a miss in a set whose four ways are all valid, `rsp_way` is the rotating pointer. The pointer then advances by one, modulo 4. No other event moves the pointer.
- R9: A fill writes the tag of `fill_addr` and all four longwords into `fill_way` of the set given by `fill_addr`. Longword k is taken from `fill_data` bits [32k+31:32k]. The line becomes valid and unmodified.
- R10: An access presented in the same cycle as a fill is ignored. It produces no response, no memory strobe and no pointer movement.
- R11: In a cycle with no accepted access, `rsp_hit`, `rsp_miss`, `mem_wr`, `rsp_way`, `rsp_dirty` and `rsp_rdata` are all zero. `rsp_hit` and `rsp_miss` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_copyback | input | 1 | 1 = copyback space, 0 = write-through |
| acc_addr | input | 32 | Access byte address |
| acc_wdata | input | 32 | Write longword |
| acc_be | input | 4 | Byte enables for a write |
| fill_valid | input | 1 | Load a full line this cycle |
| fill_addr | input | 32 | Address giving the tag and set of the fill |
| fill_way | input | 2 | Way to load |
| fill_data | input | 128 | Four longwords, longword 0 in the low bits |
| rsp_hit | output | 1 | Previous access hit |
| rsp_miss | output | 1 | Previous access missed |
| rsp_way | output | 2 | Hit way, or the way chosen for refill |
| rsp_dirty | output | 1 | Modified flag of the hit line before the access |
| rsp_rdata | output | 32 | Read-hit longword |
| mem_wr | output | 1 | Write-through strobe |
| mem_addr | output | 32 | Forwarded address, bits [1:0] cleared |
| mem_wdata | output | 32 | Forwarded data |
| mem_be | output | 4 | Forwarded byte enables |

## Verification
The stored state cannot be read directly at the ports. A wrong tag, valid flag or data word therefore shows up only when an access reaches that line: a hit is reported as a miss, or the wrong longword comes back one cycle after the access. A wrong modified flag shows up on the next hit to the line, through `rsp_dirty`. A drifted rotating pointer shows up at the next miss in any full set, where the reported way differs. The bench keeps a behavioural copy of every line and of the pointer and compares all outputs every cycle, so each such fault is reported at its first exposure.

// File: rtl/cache4_pkg.sv
// Shared geometry of the four-way line cache.
// Assumes power-of-two sets, ways and longwords per line.
package cache4_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int WORDS   = 4;
    localparam int WAYS    = 4;
    localparam int SETS    = 128;
    localparam int BE_W    = WORD_W / 8;
    localparam int BOFS_W  = $clog2(BE_W);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int OFS_W   = BOFS_W + WSEL_W;
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LINE_W  = WORDS * WORD_W;
endpackage

// File: rtl/cache4_tag_match.sv
// Parallel tag comparison for one set.
// Produces a per-way hit vector, the OR of it, and the lowest hitting way.
// Assumes the caller supplies the tags of the indexed set as one flat vector.
module cache4_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 21,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]      ref_tag,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]       way_valid,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  any_hit,
    output logic [WAY_W-1:0]      hit_way
);
    // one comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == ref_tag);
    end

    assign any_hit = |hit_vec;

    // encode the lowest-numbered hitting way
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache4_victim_sel.sv
// Refill-way chooser: lowest invalid way first, otherwise a global rotating pointer.
// The pointer advances only when a victim is taken from a full set.
// Assumes advance_req is asserted only for accepted misses.
module cache4_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  way_valid,
    input  logic             advance_req,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] rr_q;
    logic             set_full;
    logic [WAY_W-1:0] first_free;

    assign set_full = &way_valid;

    // find the lowest invalid way
    always_comb begin
        first_free = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) first_free = WAY_W'(w);
        end
    end

    assign victim = set_full ? rr_q : first_free;

    // rotating pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)                       rr_q <= '0;
        else if (advance_req && set_full) rr_q <= rr_q + 1'b1;
    end

    // R7
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_full |-> !way_valid[victim]);

    // R8
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(advance_req && set_full) |-> $stable(rr_q));
endmodule

// File: rtl/cache4_top.sv
// Four-way set-associative cache core: tag/flag/data storage, lookup,
// write-hit merge, refill-way choice and single-cycle line fill.
// Responses are registered one cycle after the access.
// Assumes longword-aligned accesses; a fill in the same cycle wins over an access.
module cache4_top
    import cache4_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_copyback,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [WORD_W-1:0]   acc_wdata,
    input  logic [BE_W-1:0]     acc_be,
    input  logic                fill_valid,
    input  logic [ADDR_W-1:0]   fill_addr,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic [LINE_W-1:0]   fill_data,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic [WAY_W-1:0]    rsp_way,
    output logic                rsp_dirty,
    output logic [WORD_W-1:0]   rsp_rdata,
    output logic                mem_wr,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [BE_W-1:0]     mem_be
);
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   mod_q   [SETS];

    logic                 acc_go;
    logic [IDX_W-1:0]     a_idx, f_idx;
    logic [TAG_W-1:0]     a_tag, f_tag;
    logic [WSEL_W-1:0]    a_wsel;
    logic [WAYS*TAG_W-1:0] set_tags;
    logic [WAYS-1:0]      hit_vec;
    logic                 any_hit;
    logic [WAY_W-1:0]     hit_way, victim;
    logic                 wr_hit;

    assign acc_go = acc_valid && !fill_valid;
    assign a_idx  = acc_addr[OFS_W +: IDX_W];
    assign a_tag  = acc_addr[ADDR_W-1 -: TAG_W];
    assign a_wsel = acc_addr[BOFS_W +: WSEL_W];
    assign f_idx  = fill_addr[OFS_W +: IDX_W];
    assign f_tag  = fill_addr[ADDR_W-1 -: TAG_W];
    assign wr_hit = acc_go && acc_write && any_hit;

    // gather the tags of the indexed set
    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[a_idx][w];
    end

    cache4_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .ref_tag   (a_tag),
        .way_tags  (set_tags),
        .way_valid (valid_q[a_idx]),
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .hit_way   (hit_way)
    );

    cache4_victim_sel #(.WAYS(WAYS)) u_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .way_valid   (valid_q[a_idx]),
        .advance_req (acc_go && !any_hit),
        .victim      (victim)
    );

    // tag and data storage: fill loads a whole line, write hit merges bytes
    always_ff @(posedge clk) begin
        if (fill_valid) begin
            tag_q[f_idx][fill_way]  <= f_tag;
            data_q[f_idx][fill_way] <= fill_data;
        end else if (wr_hit) begin
            for (int b = 0; b < BE_W; b++) begin
                if (acc_be[b])
                    data_q[a_idx][hit_way][int'(a_wsel)*WORD_W + b*8 +: 8] <= acc_wdata[b*8 +: 8];
            end
        end
    end

    // valid and modified flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                mod_q[s]   <= '0;
            end
        end else if (fill_valid) begin
            valid_q[f_idx][fill_way] <= 1'b1;
            mod_q[f_idx][fill_way]   <= 1'b0;
        end else if (wr_hit && acc_copyback) begin
            mod_q[a_idx][hit_way] <= 1'b1;
        end
    end

    // registered response and write-through strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_way   <= '0;
            rsp_dirty <= 1'b0;
            rsp_rdata <= '0;
            mem_wr    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
        end else begin
            rsp_hit   <= acc_go && any_hit;
            rsp_miss  <= acc_go && !any_hit;
            rsp_way   <= !acc_go ? '0 : (any_hit ? hit_way : victim);
            rsp_dirty <= acc_go && any_hit && mod_q[a_idx][hit_way];
            rsp_rdata <= (acc_go && any_hit && !acc_write)
                         ? data_q[a_idx][hit_way][int'(a_wsel)*WORD_W +: WORD_W] : '0;
            mem_wr    <= wr_hit && !acc_copyback;
            mem_addr  <= {acc_addr[ADDR_W-1:BOFS_W], {BOFS_W{1'b0}}};
            mem_wdata <= acc_wdata;
            mem_be    <= acc_be;
        end
    end

    // R11
    rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));

    // R10
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_miss) |-> $past(acc_valid && !fill_valid));

    // R6
    mem_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (rsp_hit && $past(acc_write && !acc_copyback)));

    // R4
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_rdata == '0));
endmodule

// File: tb/tb_cache4_top.sv
module tb_cache4_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 0, acc_write = 0, acc_copyback = 0;
    logic [31:0]  acc_addr = 0, acc_wdata = 0;
    logic [3:0]   acc_be = 0;
    logic         fill_valid = 0;
    logic [31:0]  fill_addr = 0;
    logic [1:0]   fill_way = 0;
    logic [127:0] fill_data = 0;
    logic         rsp_hit, rsp_miss, rsp_dirty, mem_wr;
    logic [1:0]   rsp_way;
    logic [31:0]  rsp_rdata, mem_addr, mem_wdata;
    logic [3:0]   mem_be;

    always #2 clk = ~clk;

    cache4_top dut (.*);

    // behavioural reference state
    logic [20:0] m_tag  [128][4];
    bit          m_val  [128][4];
    bit          m_mod  [128][4];
    logic [31:0] m_word [128][4][4];
    int          m_rr;

    logic        e_hit, e_miss, e_dirty, e_mem;
    logic [1:0]  e_way;
    logic [31:0] e_rdata, e_maddr, e_mdata;
    logic [3:0]  e_mbe;
    bit          have_exp = 0;
    int          n_cmp = 0, n_bad = 0;

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        cmp("R3", "rsp_hit", 32'(rsp_hit), 32'(e_hit));
        cmp("R7", "rsp_miss", 32'(rsp_miss), 32'(e_miss));
        cmp("R8", "rsp_way", 32'(rsp_way), 32'(e_way));
        cmp("R6", "rsp_dirty", 32'(rsp_dirty), 32'(e_dirty));
        cmp("R4", "rsp_rdata", rsp_rdata, e_rdata);
        cmp("R6", "mem_wr", 32'(mem_wr), 32'(e_mem));
        if (e_mem) begin
            cmp("R2", "mem_addr", mem_addr, e_maddr);
            cmp("R6", "mem_wdata", mem_wdata, e_mdata);
            cmp("R5", "mem_be", 32'(mem_be), 32'(e_mbe));
        end
    endtask

    // advance the reference by one cycle with the inputs now driven
    task automatic model_step();
        int idx, wsel, hw, fw;
        logic [20:0] tg;
        e_hit = 0; e_miss = 0; e_dirty = 0; e_mem = 0; e_way = 0;
        e_rdata = 0; e_maddr = 0; e_mdata = 0; e_mbe = 0;
        if (!rst_n) begin
            // R1: reset clears all flags and the pointer
            foreach (m_val[s, w]) begin m_val[s][w] = 0; m_mod[s][w] = 0; end
            m_rr = 0;
        end else if (fill_valid) begin
            // R9 fill; R10 access ignored
            idx = int'(fill_addr[10:4]);
            fw  = int'(fill_way);
            m_tag[idx][fw] = fill_addr[31:11];
            for (int k = 0; k < 4; k++) m_word[idx][fw][k] = fill_data[32*k +: 32];
            m_val[idx][fw] = 1;
            m_mod[idx][fw] = 0;
        end else if (acc_valid) begin
            idx = int'(acc_addr[10:4]);
            tg = acc_addr[31:11];
            wsel = int'(acc_addr[3:2]);
            hw = -1;
            for (int w = 3; w >= 0; w--)
                if (m_val[idx][w] && m_tag[idx][w] == tg) hw = w;
            if (hw >= 0) begin
                e_hit = 1;
                e_way = 2'(hw);
                e_dirty = m_mod[idx][hw];
                if (acc_write) begin
                    for (int b = 0; b < 4; b++)
                        if (acc_be[b]) m_word[idx][hw][wsel][8*b +: 8] = acc_wdata[8*b +: 8];
                    if (acc_copyback) m_mod[idx][hw] = 1;
                    else begin
                        e_mem = 1;
                        e_maddr = {acc_addr[31:2], 2'b00};
                        e_mdata = acc_wdata;
                        e_mbe = acc_be;
                    end
                end else begin
                    e_rdata = m_word[idx][hw][wsel];
                end
            end else begin
                e_miss = 1;
                fw = -1;
                for (int w = 3; w >= 0; w--) if (!m_val[idx][w]) fw = w;
                if (fw >= 0) e_way = 2'(fw);
                else begin
                    e_way = 2'(m_rr);
                    m_rr = (m_rr + 1) % 4;
                end
            end
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        if (have_exp) compare_all();
    endtask

    // drive one cycle of stimulus and step the reference
    task automatic drive(input bit av, input bit wr, input bit cb, input logic [31:0] ad,
                         input logic [31:0] wd, input logic [3:0] be,
                         input bit fv, input logic [31:0] fa, input logic [1:0] fwy, input logic [127:0] fd);
        cycle();
        acc_valid = av; acc_write = wr; acc_copyback = cb; acc_addr = ad;
        acc_wdata = wd; acc_be = be;
        fill_valid = fv; fill_addr = fa; fill_way = fwy; fill_data = fd;
        model_step();
        have_exp = 1;
    endtask

    function automatic logic [31:0] mk(input logic [20:0] tg, input logic [6:0] ix, input logic [1:0] ws, input logic [1:0] bo);
        return {tg, ix, ws, bo};
    endfunction

    task automatic rd(input logic [31:0] a);
        drive(1, 0, 0, a, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input bit cb, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        drive(1, 1, cb, a, d, be, 0, 0, 0, 0);
    endtask
    task automatic fill(input logic [31:0] a, input logic [1:0] w, input logic [127:0] d);
        drive(0, 0, 0, 0, 0, 0, 1, a, w, d);
    endtask
    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs zero during reset
        rst_n = 0;
        repeat (3) idle();
        rst_n = 1;
        // R11: idle cycle gives zero outputs
        idle();
        // R1/R7: empty set misses with way 0
        rd(mk(21'h1A5A5, 7'd5, 2'd0, 2'd0));
        // R9: fill way 0
        fill(mk(21'h1A5A5, 7'd5, 0, 0), 2'd0, 128'h44444444_33333333_22222222_11111111);
        // R4/R2: every longword, byte offset bits set
        for (int k = 0; k < 4; k++) rd(mk(21'h1A5A5, 7'd5, 2'(k), 2'd3));
        // R5/R6: copyback merge, then dirty seen on read
        wr(1, mk(21'h1A5A5, 7'd5, 2'd1, 2'd0), 32'hAABBCCDD, 4'b0101);
        rd(mk(21'h1A5A5, 7'd5, 2'd1, 2'd0));
        // R6: write-through hit forwards and stays clean
        fill(mk(21'h00777, 7'd5, 0, 0), 2'd1, 128'hDEAD0003_DEAD0002_DEAD0001_DEAD0000);
        wr(0, mk(21'h00777, 7'd5, 2'd2, 2'd2), 32'h12345678, 4'b1110);
        rd(mk(21'h00777, 7'd5, 2'd2, 2'd0));
        // R7: next invalid way is 2
        rd(mk(21'h00001, 7'd5, 2'd0, 2'd0));
        fill(mk(21'h00001, 7'd5, 0, 0), 2'd2, 128'h1);
        fill(mk(21'h00002, 7'd5, 0, 0), 2'd3, 128'h2);
        // R8: full set rotates 0,1,2,3,0
        for (int k = 0; k < 5; k++) rd(mk(21'h0BEEF, 7'd5, 2'd0, 2'd0));
        // R10: access during fill ignored
        drive(1, 1, 0, mk(21'h1A5A5, 7'd5, 2'd0, 2'd0), 32'hFFFFFFFF, 4'hF,
              1, mk(21'h05555, 7'd9, 0, 0), 2'd0, 128'h9);
        rd(mk(21'h1A5A5, 7'd5, 2'd0, 2'd0));
        // R3: same tag other set, other tag same set
        rd(mk(21'h1A5A5, 7'd6, 2'd0, 2'd0));
        rd(mk(21'h1A5A4, 7'd5, 2'd0, 2'd0));
        // mixed traffic on a few sets and tags
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [31:0] a;
            r = $urandom_range(0, 9);
            a = mk(21'($urandom_range(0, 3)), 7'($urandom_range(5, 7)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            if (r < 4)       rd(a);
            else if (r < 7)  wr(1'($urandom_range(0, 1)), a, $urandom, 4'($urandom_range(0, 15)));
            else if (r < 9)  fill(a, 2'($urandom_range(0, 3)), {$urandom, $urandom, $urandom, $urandom});
            else if (r == 9) idle();
        end
        idle();
        cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule